// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects thirty-two interrupt request lines and drives two active-low interrupt outputs toward a processor. One is a normal interrupt and one is a fast interrupt. Each request line can come from hardware, from a bit that software sets, or from both. Software then decides for each source whether it is enabled and which of the two outputs it goes to. For the normal path, every source carries its own 4-bit priority level and its own 32-bit vector address. A 16-bit level mask can silence whole priority levels. The controller always presents the vector of the best pending request.

An interrupt handler claims its request by reading the current-vector register. That read returns the winning vector and pushes the winner's level onto an in-service stack. While a level is in service, only requests at a strictly more urgent level can raise the normal output again. This is how nested interrupts work. Any write to the same register retires the most recent level. An upstream controller can be chained in front: its fast request joins the fast output, and its normal request competes like an extra source with a programmable level and the vector it supplies.

Software reaches the block through a plain word-addressed register bus with single-cycle read and write strobes. Read data is combinational from the current address.

Top module: `prio_vic`

## Requirements
- R1: The raw status of source n is irq_src[n] OR software bit n, and offset 0x008 reads back all 32 raw bits.
- R2: The select register at 0x00C sends source n to the fast path when bit n is 1 and to the normal path when it is 0. Offset 0x000 reads raw AND enable AND NOT select. Offset 0x004 reads raw AND enable AND select.
- R3: Writing 1s to 0x010 sets enable bits and writing 1s to 0x014 clears them. Written 0s change nothing. 0x010 reads the enable bits and 0x014 reads as zero.
- R4: Writing 1s to 0x018 sets software interrupt bits and writing 1s to 0x01C clears them. 0x018 reads the bits and 0x01C reads as zero.
- R5: fiq_n is low, in the same cycle, exactly when any fast-path status bit is set or chain_fiq_n is low.
- R6: Source n has a 32-bit vector at 0x100+4n and a 4-bit level at 0x200+4n (bits 3:0, upper bits read zero). Both read back what was written.
- R7: irq_n is low when a normal-path request beats the in-service ceiling. Level 0 is the most urgent. Among equal levels, the lower source index wins, and every source beats a chained request at the same level. vec_out shows the winner's vector while irq_n is low and is zero otherwise.
- R8: The mask at 0x024 (bits 15:0) has one bit per level. A 0 at bit L keeps every request at level L, including the chained one, out of the normal arbitration.
- R9: While chain_irq_n is low, the chained request competes at the level held in 0x028 (bits 3:0) and supplies chain_vec as its vector.
- R10: A read of 0xF00 returns the winning vector and pushes its level as in service. With no winner, the read returns zero and changes nothing.
- R11: While a level is in service, only requests at a numerically smaller level drive irq_n low.
- R12: Any write to 0xF00 pops the most recent in-service level, which restores the previous ceiling. A write with nothing in service does nothing.
- R13: Unmapped offsets read as zero. After reset, enables, selects and software bits are zero, every level (source and chained) is 15, the mask is 0x0000FFFF and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Hardware interrupt request lines, active high |
| chain_irq_n | input | 1 | Upstream normal request, active low |
| chain_fiq_n | input | 1 | Upstream fast request, active low |
| chain_vec | input | 32 | Vector supplied by the upstream controller |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access; never high together with bus_rd |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_n | output | 1 | Normal interrupt to the processor, active low |
| fiq_n | output | 1 | Fast interrupt to the processor, active low |
| vec_out | output | 32 | Vector of the current normal winner, zero when none |

## Verification
The embedded assertions watch, on every cycle, the register-level effects of a set or clear write and the in-service stack depth on each claim and retire. They also check that a pushed level always beats the previous ceiling, that no masked level ever wins, and that an upstream fast request always reaches fiq_n. Only the bench's scenarios can show the arbitration order itself: the lowest level winning, the lower index breaking a tie, and a source beating the chained request at an equal level. The same holds for nested claim and retire sequences restoring the right ceiling and for the read-back values of the whole register map. A behavioural model compares every output on each clock across a long randomized run.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC    = 32;
  localparam int PRIO_W  = 4;
  localparam int NLVL    = 1 << PRIO_W;
  localparam int CEIL_W  = PRIO_W + 1;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int IDX_W   = $clog2(NSRC);

  typedef logic [PRIO_W-1:0] lvl_t;
  typedef logic [CEIL_W-1:0] ceil_t;

  localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RAW      = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ROUTE    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SW_SET   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_SW_CLR   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_LVL_MASK = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_CHN_LVL  = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_CUR_VEC  = 12'hF00;
  localparam logic [3:0]        PAGE_VECT    = 4'h1;
  localparam logic [3:0]        PAGE_LVL     = 4'h2;

  // A level beats a ceiling when it is numerically smaller; ceiling NLVL means idle.
  function automatic logic outranks(input lvl_t lvl, input ceil_t bar);
    return {1'b0, lvl} < bar;
  endfunction

  // True when an address selects an entry of a per-source table page.
  function automatic logic table_hit(input logic [ADDR_W-1:0] a, input logic [3:0] page);
    return (a[ADDR_W-1:8] == page) && (a[1:0] == 2'b00) && (int'(a[7:2]) < NSRC);
  endfunction
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  parameter int NL = NLVL,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         irq_src,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic [DW-1:0]        cur_vec_rd,
  output logic [DW-1:0]        bus_rdata,
  output logic [N-1:0]         irq_stat,
  output logic [N-1:0]         fiq_stat,
  output logic [N-1:0][PW-1:0] src_lvl,
  output logic [N-1:0][DW-1:0] src_vec,
  output logic [NL-1:0]        lvl_mask,
  output logic [PW-1:0]        chain_lvl
);
  logic [N-1:0] en_q, route_q, sw_q, raw;
  logic         vect_hit, lvl_hit;
  logic [IW-1:0] tidx;

  assign raw      = irq_src | sw_q;
  assign irq_stat = raw & en_q & ~route_q;
  assign fiq_stat = raw & en_q & route_q;
  assign vect_hit = table_hit(bus_addr, PAGE_VECT);
  assign lvl_hit  = table_hit(bus_addr, PAGE_LVL);
  assign tidx     = bus_addr[IW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      route_q   <= '0;
      sw_q      <= '0;
      lvl_mask  <= '1;
      chain_lvl <= '1;
      for (int i = 0; i < N; i++) begin
        src_lvl[i] <= '1;
        src_vec[i] <= '0;
      end
    end else if (bus_wr) begin
      unique case (bus_addr)
        OFS_ROUTE:    route_q   <= bus_wdata[N-1:0];
        OFS_EN_SET:   en_q      <= en_q | bus_wdata[N-1:0];
        OFS_EN_CLR:   en_q      <= en_q & ~bus_wdata[N-1:0];
        OFS_SW_SET:   sw_q      <= sw_q | bus_wdata[N-1:0];
        OFS_SW_CLR:   sw_q      <= sw_q & ~bus_wdata[N-1:0];
        OFS_LVL_MASK: lvl_mask  <= bus_wdata[NL-1:0];
        OFS_CHN_LVL:  chain_lvl <= bus_wdata[PW-1:0];
        default: begin
          if (vect_hit) src_vec[tidx] <= bus_wdata;
          if (lvl_hit)  src_lvl[tidx] <= bus_wdata[PW-1:0];
        end
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_IRQ_STAT: bus_rdata[N-1:0]  = irq_stat;
      OFS_FIQ_STAT: bus_rdata[N-1:0]  = fiq_stat;
      OFS_RAW:      bus_rdata[N-1:0]  = raw;
      OFS_ROUTE:    bus_rdata[N-1:0]  = route_q;
      OFS_EN_SET:   bus_rdata[N-1:0]  = en_q;
      OFS_SW_SET:   bus_rdata[N-1:0]  = sw_q;
      OFS_LVL_MASK: bus_rdata[NL-1:0] = lvl_mask;
      OFS_CHN_LVL:  bus_rdata[PW-1:0] = chain_lvl;
      OFS_CUR_VEC:  bus_rdata         = cur_vec_rd;
      default: begin
        if (vect_hit)     bus_rdata          = src_vec[tidx];
        else if (lvl_hit) bus_rdata[PW-1:0]  = src_lvl[tidx];
      end
    endcase
  end

  // R3: set and clear writes act on exactly the bits written as 1
  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET) |=> ((en_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));
  assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_CLR) |=> ((en_q & $past(bus_wdata[N-1:0])) == '0));
  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET) |=> ((en_q & ~$past(bus_wdata[N-1:0])) == ($past(en_q) & ~$past(bus_wdata[N-1:0]))));
  // R4: software clear removes the written bits
  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SW_CLR) |=> ((sw_q & $past(bus_wdata[N-1:0])) == '0));
  // R13: no read strobe alters the enable state
  assert_read_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> $stable(en_q));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  parameter int NL = NLVL,
  parameter int CW = CEIL_W,
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         irq_stat,
  input  logic [N-1:0][PW-1:0] src_lvl,
  input  logic [N-1:0][DW-1:0] src_vec,
  input  logic [NL-1:0]        lvl_mask,
  input  logic                 chain_req,
  input  logic [PW-1:0]        chain_lvl,
  input  logic [DW-1:0]        chain_vec,
  input  logic [CW-1:0]        ceiling,
  output logic                 win_valid,
  output logic [PW-1:0]        win_lvl,
  output logic [DW-1:0]        win_vec
);
  logic [CW-1:0] best;
  logic [IW-1:0] best_idx;
  logic          best_chain;

  // Strict comparison in index order keeps the lowest index among equal levels;
  // the chained request is examined last so sources win its ties.
  always_comb begin
    best       = CW'(NL);
    best_idx   = '0;
    best_chain = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (irq_stat[i] && lvl_mask[src_lvl[i]] && outranks(src_lvl[i], best)) begin
        best     = {1'b0, src_lvl[i]};
        best_idx = IW'(i);
      end
    end
    if (chain_req && lvl_mask[chain_lvl] && outranks(chain_lvl, best)) begin
      best       = {1'b0, chain_lvl};
      best_chain = 1'b1;
    end
  end

  assign win_lvl   = best[PW-1:0];
  assign win_valid = (best < ceiling);
  assign win_vec   = best_chain ? chain_vec : src_vec[best_idx];

  // R8: a level whose mask bit is clear never produces the winner
  assert_win_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> lvl_mask[win_lvl]);
  // R7: a winner only exists if some normal request or the chain is pending
  assert_win_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irq_stat != '0 || chain_req));
endmodule

// File: rtl/vic_svc_stack.sv
module vic_svc_stack
  import vic_pkg::*;
#(
  parameter int PW = PRIO_W,
  parameter int NL = NLVL,
  parameter int CW = CEIL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_lvl,
  input  logic          pop,
  output logic [CW-1:0] ceiling,
  output logic [CW-1:0] depth
);
  logic [PW-1:0] stk [NL];
  logic [PW-1:0] top_idx;

  assign top_idx = PW'(depth - CW'(1));
  assign ceiling = (depth == '0) ? CW'(NL) : {1'b0, stk[top_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < NL; i++) stk[i] <= '0;
    end else if (push) begin
      stk[depth[PW-1:0]] <= push_lvl;
      depth <= depth + CW'(1);
    end else if (pop && depth != '0) begin
      depth <= depth - CW'(1);
    end
  end

  // R11: each pushed level is strictly more urgent than the ceiling it replaces
  assert_push_strict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> outranks(push_lvl, ceiling));
  // R10: a claim deepens the stack by one and exposes the claimed level
  assert_push_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (depth == $past(depth) + CW'(1)) && (ceiling == {1'b0, $past(push_lvl)}));
  // R12: a retire removes one entry; an empty stack stays empty
  assert_pop_depth_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth != '0) |=> depth == $past(depth) - CW'(1));
  assert_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth == '0) |=> depth == '0);
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(NL));
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import vic_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  parameter int NL = NLVL,
  parameter int CW = CEIL_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_src,
  input  logic          chain_irq_n,
  input  logic          chain_fiq_n,
  input  logic [DW-1:0] chain_vec,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n,
  output logic          fiq_n,
  output logic [DW-1:0] vec_out
);
  logic [N-1:0]         irq_stat, fiq_stat;
  logic [N-1:0][PW-1:0] src_lvl;
  logic [N-1:0][DW-1:0] src_vec;
  logic [NL-1:0]        lvl_mask;
  logic [PW-1:0]        chain_lvl, win_lvl;
  logic [DW-1:0]        win_vec;
  logic                 win_valid;
  logic [CW-1:0]        ceiling, depth;
  logic                 claim_evt, retire_evt;

  assign claim_evt  = bus_rd && (bus_addr == OFS_CUR_VEC) && win_valid;
  assign retire_evt = bus_wr && (bus_addr == OFS_CUR_VEC);
  assign vec_out    = win_valid ? win_vec : '0;
  assign irq_n      = ~win_valid;
  assign fiq_n      = ~((|fiq_stat) || !chain_fiq_n);

  vic_regfile #(.N(N), .PW(PW), .NL(NL), .DW(DW), .AW(AW), .IW(IW)) regs_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cur_vec_rd(vec_out), .bus_rdata(bus_rdata),
    .irq_stat(irq_stat), .fiq_stat(fiq_stat), .src_lvl(src_lvl), .src_vec(src_vec),
    .lvl_mask(lvl_mask), .chain_lvl(chain_lvl)
  );

  vic_arbiter #(.N(N), .PW(PW), .NL(NL), .CW(CW), .DW(DW), .IW(IW)) arb_i (
    .clk(clk), .rst_n(rst_n), .irq_stat(irq_stat), .src_lvl(src_lvl), .src_vec(src_vec),
    .lvl_mask(lvl_mask), .chain_req(!chain_irq_n), .chain_lvl(chain_lvl),
    .chain_vec(chain_vec), .ceiling(ceiling),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_vec(win_vec)
  );

  vic_svc_stack #(.PW(PW), .NL(NL), .CW(CW)) stk_i (
    .clk(clk), .rst_n(rst_n), .push(claim_evt), .push_lvl(win_lvl), .pop(retire_evt),
    .ceiling(ceiling), .depth(depth)
  );

  // R5: an upstream fast request always reaches the fast output
  assert_chain_fiq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_fiq_n |-> !fiq_n);
  // R7: with no normal request anywhere, the normal output stays idle
  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat == '0 && chain_irq_n) |-> (irq_n && vec_out == '0));
  // R10: a claim read returns a nonzero-capable vector only while irq_n is low
  assert_claim_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CUR_VEC && irq_n) |-> bus_rdata == '0);
  // R11: once claimed, the same level cannot immediately assert again
  assert_claim_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    claim_evt |=> (irq_n || win_lvl < $past(win_lvl)));
endmodule

// File: tb/prio_vic_tb_top.sv
module prio_vic_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        chain_irq_n = 1'b1, chain_fiq_n = 1'b1;
  logic [31:0] chain_vec = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, vec_out;
  logic        irq_n, fiq_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_vic dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .chain_irq_n(chain_irq_n),
    .chain_fiq_n(chain_fiq_n), .chain_vec(chain_vec), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .fiq_n(fiq_n), .vec_out(vec_out)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_en, m_sel, m_sw, m_vect [32];
  bit [15:0] m_mask;
  int        m_clvl;
  int        m_lvl [32];
  int        m_stack [$];

  task automatic m_reset();
    m_en = 0; m_sel = 0; m_sw = 0; m_mask = 16'hFFFF; m_clvl = 15;
    for (int n = 0; n < 32; n++) begin m_vect[n] = 0; m_lvl[n] = 15; end
    m_stack.delete();
  endtask

  // Search level by level, then source by source, chain last.
  function automatic void m_pick(output bit ok, output int lvl, output bit [31:0] vec);
    int ceil_l = (m_stack.size() == 0) ? 16 : m_stack[$];
    bit [31:0] pend = (irq_src | m_sw) & m_en & ~m_sel;
    ok = 0; lvl = 16; vec = 0;
    for (int l = 0; l < 16 && !ok; l++) begin
      if (m_mask[l]) begin
        for (int n = 0; n < 32 && !ok; n++)
          if (pend[n] && m_lvl[n] == l) begin ok = 1; lvl = l; vec = m_vect[n]; end
        if (!ok && !chain_irq_n && m_clvl == l) begin ok = 1; lvl = l; vec = chain_vec; end
      end
    end
    if (ok && lvl >= ceil_l) begin ok = 0; vec = 0; end
  endfunction

  function automatic bit [31:0] m_read(input bit [11:0] a);
    bit ok; int l; bit [31:0] v;
    bit [31:0] raw = irq_src | m_sw;
    m_pick(ok, l, v);
    case (a)
      12'h000: return raw & m_en & ~m_sel;
      12'h004: return raw & m_en & m_sel;
      12'h008: return raw;
      12'h00C: return m_sel;
      12'h010: return m_en;
      12'h018: return m_sw;
      12'h024: return {16'h0, m_mask};
      12'h028: return 32'(m_clvl);
      12'hF00: return v;
      default: begin
        if (a[1:0] == 0 && a[11:8] == 4'h1 && a[7] == 0) return m_vect[a[6:2]];
        if (a[1:0] == 0 && a[11:8] == 4'h2 && a[7] == 0) return 32'(m_lvl[a[6:2]]);
        return 0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    bit ok; int l; bit [31:0] v;
    if (!rst_n) m_reset();
    else begin
      m_pick(ok, l, v);
      if (bus_rd && bus_addr == 12'hF00 && ok) m_stack.push_back(l);
      if (bus_wr) begin
        case (bus_addr)
          12'h00C: m_sel = bus_wdata;
          12'h010: m_en = m_en | bus_wdata;
          12'h014: m_en = m_en & ~bus_wdata;
          12'h018: m_sw = m_sw | bus_wdata;
          12'h01C: m_sw = m_sw & ~bus_wdata;
          12'h024: m_mask = bus_wdata[15:0];
          12'h028: m_clvl = int'(bus_wdata[3:0]);
          12'hF00: if (m_stack.size() != 0) void'(m_stack.pop_back());
          default: begin
            if (bus_addr[1:0] == 0 && bus_addr[11:8] == 4'h1 && bus_addr[7] == 0)
              m_vect[bus_addr[6:2]] = bus_wdata;
            if (bus_addr[1:0] == 0 && bus_addr[11:8] == 4'h2 && bus_addr[7] == 0)
              m_lvl[bus_addr[6:2]] = int'(bus_wdata[3:0]);
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    bit ok; int l; bit [31:0] v;
    bit [31:0] fst;
    #2;
    if (rst_n) begin
      m_pick(ok, l, v);
      fst = (irq_src | m_sw) & m_en & m_sel;
      chk("R7 irq_n (model)", {31'b0, irq_n}, {31'b0, !ok});
      chk("R10 vec_out (model)", vec_out, v);
      chk("R5 fiq_n (model)", {31'b0, fiq_n}, {31'b0, !((fst != 0) || !chain_fiq_n)});
      if (bus_rd) chk("R13 bus_rdata (model)", bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic br(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_wr = 0; bus_addr = a;
    #3 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk); irq_src = v; #3;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] s;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R13: reset values and unmapped space
    br(12'h024, d); chk("R13 mask reset", d, 32'h0000FFFF);
    br(12'h228, d); chk("R13 level reset", d, 32'hF);
    br(12'h028, d); chk("R13 chain level reset", d, 32'hF);
    br(12'h010, d); chk("R13 enable reset", d, 0);
    br(12'h040, d); chk("R13 unmapped", d, 0);
    chk("R13 irq_n idle", {31'b0, irq_n}, 1);

    // R3: set/clear enables, zeros ignored
    bw(12'h010, 32'hFF); bw(12'h010, 32'h0); bw(12'h014, 32'h3); bw(12'h014, 32'h0);
    br(12'h010, d); chk("R3 enable set/clear", d, 32'hFC);
    br(12'h014, d); chk("R3 clear reg reads zero", d, 0);

    // R1, R4: software bits
    set_src(32'h100);
    bw(12'h018, 32'h10);
    br(12'h008, d); chk("R1 raw = hw|sw", d, 32'h110);
    br(12'h018, d); chk("R4 sw readback", d, 32'h10);
    br(12'h01C, d); chk("R4 sw clear reads zero", d, 0);
    bw(12'h01C, 32'h10);
    br(12'h018, d); chk("R4 sw cleared", d, 0);
    set_src(0);

    // R2, R5: fast routing
    bw(12'h00C, 32'h4);
    set_src(32'h4);
    br(12'h004, d); chk("R2 fiq status", d, 32'h4);
    br(12'h000, d); chk("R2 irq status", d, 0);
    chk("R5 fiq_n low", {31'b0, fiq_n}, 0);
    chk("R2 irq_n high", {31'b0, irq_n}, 1);
    set_src(0);
    chk("R5 fiq_n released", {31'b0, fiq_n}, 1);
    @(negedge clk) chain_fiq_n = 0; #3;
    chk("R5 chain fiq", {31'b0, fiq_n}, 0);
    @(negedge clk) chain_fiq_n = 1;
    bw(12'h00C, 0);

    // R6: vector and level tables
    for (int n = 0; n < 32; n++) bw(12'(12'h100 + 4 * n), 32'h8000_0000 + 32'(n * 16));
    br(12'h11C, d); chk("R6 vector readback", d, 32'h80000070);
    bw(12'h010, 32'hFFFFFFFF);
    bw(12'h20C, 32'hFFFFFFF5); bw(12'h21C, 2); bw(12'h224, 2);
    br(12'h20C, d); chk("R6 level 4 bits", d, 32'h5);

    // R7: lowest level, tie to lower index
    s = (1 << 3) | (1 << 7) | (1 << 9);
    set_src(s);
    chk("R7 irq asserted", {31'b0, irq_n}, 0);
    chk("R7 tie lower index", vec_out, 32'h80000070);
    // R8: mask level 2
    bw(12'h024, 32'hFFFB);
    chk("R8 masked level skipped", vec_out, 32'h80000030);
    bw(12'h024, 32'hFFFF);

    // R10, R11: claim and nesting
    br(12'hF00, d); chk("R10 claim vector", d, 32'h80000070);
    chk("R11 same level blocked", {31'b0, irq_n}, 1);
    br(12'hF00, d); chk("R10 claim with no winner", d, 0);
    bw(12'h22C, 1);
    s = s | (1 << 11);
    set_src(s);
    chk("R11 higher level preempts", vec_out, 32'h800000B0);
    br(12'hF00, d); chk("R10 nested claim", d, 32'h800000B0);
    chk("R11 nested blocked", {31'b0, irq_n}, 1);

    // R12: retire restores ceilings
    bw(12'hF00, 0);
    chk("R12 pop to level 2 ceiling", vec_out, 32'h800000B0);
    s = s & ~(32'(1) << 11);
    set_src(s);
    chk("R12 ceiling 2 holds", {31'b0, irq_n}, 1);
    bw(12'hF00, 0);
    chk("R12 stack empty", vec_out, 32'h80000070);
    bw(12'hF00, 0);
    chk("R12 pop on empty harmless", vec_out, 32'h80000070);

    // R9: chained request
    @(negedge clk) begin chain_vec = 32'hCAFE0000; chain_irq_n = 0; end
    bw(12'h028, 0);
    chk("R9 chain wins at level 0", vec_out, 32'hCAFE0000);
    bw(12'h028, 2);
    chk("R9 source beats chain on tie", vec_out, 32'h80000070);
    set_src(0);
    chk("R9 chain alone", vec_out, 32'hCAFE0000);
    @(negedge clk) chain_irq_n = 1; #3;
    chk("R9 chain released", {31'b0, irq_n}, 1);

    // Randomized traffic checked by the model every clock
    void'($urandom(7));
    for (int k = 0; k < 1500; k++) begin
      int r = $urandom_range(0, 15);
      logic [11:0] a;
      case ($urandom_range(0, 9))
        0: a = 12'h00C; 1: a = 12'h010; 2: a = 12'h014; 3: a = 12'h018;
        4: a = 12'h01C; 5: a = 12'h024; 6: a = 12'h028;
        7: a = 12'(12'h100 + 4 * $urandom_range(0, 31));
        8: a = 12'(12'h200 + 4 * $urandom_range(0, 31));
        default: a = 12'hF00;
      endcase
      if (r < 3) begin
        @(negedge clk);
        irq_src = $urandom() & $urandom();
        chain_irq_n = $urandom_range(0, 3) != 0;
        chain_fiq_n = $urandom_range(0, 7) != 0;
        chain_vec = $urandom();
      end else if (r < 9) br(($urandom_range(0, 3) == 0) ? 12'hF00 : a, d);
      else if (r < 12) bw(a, (a == 12'h024) ? ($urandom() | 32'h00F0) : $urandom());
      else bw(12'hF00, 0);
    end

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule